// File: doc/BRIEF.md
# Single-Bit Test and Modify Unit

This unit takes one destination operand and a bit number, reports whether the addressed bit was clear through the zero flag, and returns the operand with that bit left alone, inverted, cleared or set. The destination may be a full-width register or a single memory byte. The bit number wraps at the width of the destination kind, so one bit-number source serves both cases. The bit number may come from an instruction immediate or from a data register.

The caller presents one request per cycle with `in_valid`. The registered result appears one clock later with `out_valid`. A write-back strobe tells the surrounding datapath whether the operand has to be stored again. Operand fetch and store are outside this block. The zero flag is the only condition flag the unit changes. The other flags are carried through unchanged.

Top module: `bit_test_unit`

## Requirements
- R1: The Z bit of `flags_out` equals the complement of the selected destination bit as it was before any modification.
- R2: Operation code 0 (test only) returns the destination value unchanged.
- R3: Operation code 1 (test and change) returns the destination with the selected bit inverted and every other bit unchanged.
- R4: Operation code 2 (test and clear) returns the destination with the selected bit forced to 0.
- R5: Operation code 3 (test and set) returns the destination with the selected bit forced to 1.
- R6: When `dest_is_mem` is 0, the destination is `REG_W` (32) bits wide and the selected bit is `bit_num` modulo 32, so bit numbers of 32 and above wrap.
- R7: When `dest_is_mem` is 1, the selected bit is `bit_num` modulo 8, only the low 8 bits of the input are used, and result bits 31..8 are driven to 0.
- R8: `wr_en` is high together with `out_valid` for operation codes 1, 2 and 3. It is low for code 0 and whenever `out_valid` is low.
- R9: `flags_out` uses the layout bit4=X, bit3=N, bit2=Z, bit1=V, bit0=C. Every bit except Z is copied from `flags_in` of the same request.
- R10: `out_valid` follows `in_valid` by exactly one clock. An active-low reset clears `out_valid`, `wr_en`, `result` and `flags_out` to 0.
- R11: In a cycle without `in_valid`, the next cycle has `out_valid` and `wr_en` low, and `result` and `flags_out` keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present this cycle |
| op | input | 2 | 0 test, 1 change, 2 clear, 3 set |
| bit_num | input | BNUM_W (8) | Bit number, from immediate or register |
| dest_in | input | REG_W (32) | Destination operand |
| dest_is_mem | input | 1 | 1 = memory byte, 0 = register |
| flags_in | input | FLAG_W (5) | Condition flags before the operation |
| out_valid | output | 1 | Result valid, one clock after request |
| wr_en | output | 1 | Destination must be written back |
| result | output | REG_W (32) | Modified destination |
| flags_out | output | FLAG_W (5) | Flags with Z updated |

## Verification
The bench builds the unit with its default parameters: a 32-bit register width, an 8-bit memory width and an 8-bit bit number. Bit numbers therefore run up to 255. That exposes the wrap at 32 for registers and the wrap at 8 for bytes, including values that hit the same physical bit through different wraps. Memory operands carry non-zero upper bits, so a missing zero mask on the upper bits shows up. Idle cycles are mixed with back-to-back requests to check that results hold and that the write strobe stays tied to valid.

// File: rtl/bt_pkg.sv
package bt_pkg;
  typedef enum logic [1:0] {
    BT_TEST = 2'd0,
    BT_FLIP = 2'd1,
    BT_CLR  = 2'd2,
    BT_SET  = 2'd3
  } bt_op_e;

  // true when the operation stores the operand back
  function automatic logic bt_writes(input bt_op_e o);
    return o != BT_TEST;
  endfunction
endpackage

// File: rtl/bt_index.sv
module bt_index #(
  parameter int BNUM_W = 8,
  parameter int REG_IW = 5,
  parameter int MEM_IW = 3
) (
  input  logic [BNUM_W-1:0] bit_num,
  input  logic              is_mem,
  output logic [REG_IW-1:0] idx
);
  logic [REG_IW-1:0] reg_idx;
  logic [REG_IW-1:0] mem_idx;

  assign reg_idx = bit_num[REG_IW-1:0];

  generate
    if (REG_IW > MEM_IW) begin : g_pad
      assign mem_idx = {{(REG_IW-MEM_IW){1'b0}}, bit_num[MEM_IW-1:0]};
    end else begin : g_same
      assign mem_idx = bit_num[REG_IW-1:0];
    end
  endgenerate

  assign idx = is_mem ? mem_idx : reg_idx;
endmodule

// File: rtl/bt_modify.sv
module bt_modify
  import bt_pkg::*;
#(
  parameter int REG_W  = 32,
  parameter int MEM_W  = 8,
  parameter int REG_IW = 5
) (
  input  logic [REG_W-1:0]  dest,
  input  logic [REG_IW-1:0] idx,
  input  bt_op_e            op,
  input  logic              is_mem,
  output logic [REG_W-1:0]  new_val,
  output logic              z
);
  localparam logic [REG_W-1:0] MEM_KEEP = {{(REG_W-MEM_W){1'b0}}, {MEM_W{1'b1}}};

  function automatic logic [REG_W-1:0] apply_op(
    input logic [REG_W-1:0] v, input logic [REG_W-1:0] m, input bt_op_e o);
    case (o)
      BT_FLIP: return v ^ m;
      BT_CLR:  return v & ~m;
      BT_SET:  return v | m;
      default: return v;
    endcase
  endfunction

  logic [REG_W-1:0] sel_mask;
  logic [REG_W-1:0] src;
  logic             old_bit;

  assign sel_mask = {{(REG_W-1){1'b0}}, 1'b1} << idx;
  assign src      = is_mem ? (dest & MEM_KEEP) : dest;
  assign old_bit  = |(src & sel_mask);
  assign z        = ~old_bit;
  assign new_val  = apply_op(src, sel_mask, op);
endmodule

// File: rtl/bt_stage.sv
module bt_stage #(
  parameter int REG_W  = 32,
  parameter int FLAG_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              wr_next,
  input  logic [REG_W-1:0]  val_next,
  input  logic [FLAG_W-1:0] flg_next,
  output logic              vld_q,
  output logic              wr_q,
  output logic [REG_W-1:0]  val_q,
  output logic [FLAG_W-1:0] flg_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      wr_q  <= 1'b0;
      val_q <= '0;
      flg_q <= '0;
    end else begin
      vld_q <= load;
      wr_q  <= load & wr_next;
      if (load) begin
        val_q <= val_next;
        flg_q <= flg_next;
      end
    end
  end
endmodule

// File: rtl/bit_test_unit.sv
module bit_test_unit
  import bt_pkg::*;
#(
  parameter int REG_W  = 32,
  parameter int MEM_W  = 8,
  parameter int BNUM_W = 8,
  parameter int FLAG_W = 5,
  parameter int Z_POS  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [1:0]        op,
  input  logic [BNUM_W-1:0] bit_num,
  input  logic [REG_W-1:0]  dest_in,
  input  logic              dest_is_mem,
  input  logic [FLAG_W-1:0] flags_in,
  output logic              out_valid,
  output logic              wr_en,
  output logic [REG_W-1:0]  result,
  output logic [FLAG_W-1:0] flags_out
);
  localparam int REG_IW = $clog2(REG_W);
  localparam int MEM_IW = $clog2(MEM_W);

  bt_op_e            op_e;
  logic [REG_IW-1:0] eff_idx;
  logic [REG_W-1:0]  mod_val;
  logic              z_next;
  logic              wr_next;
  logic [FLAG_W-1:0] flg_next;

  assign op_e    = bt_op_e'(op);
  assign wr_next = bt_writes(op_e);

  bt_index #(.BNUM_W(BNUM_W), .REG_IW(REG_IW), .MEM_IW(MEM_IW)) u_idx (
    .bit_num (bit_num),
    .is_mem  (dest_is_mem),
    .idx     (eff_idx)
  );

  bt_modify #(.REG_W(REG_W), .MEM_W(MEM_W), .REG_IW(REG_IW)) u_mod (
    .dest    (dest_in),
    .idx     (eff_idx),
    .op      (op_e),
    .is_mem  (dest_is_mem),
    .new_val (mod_val),
    .z       (z_next)
  );

  always_comb begin
    flg_next        = flags_in;
    flg_next[Z_POS] = z_next;
  end

  bt_stage #(.REG_W(REG_W), .FLAG_W(FLAG_W)) u_stage (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (in_valid),
    .wr_next  (wr_next),
    .val_next (mod_val),
    .flg_next (flg_next),
    .vld_q    (out_valid),
    .wr_q     (wr_en),
    .val_q    (result),
    .flg_q    (flags_out)
  );
endmodule

// File: rtl/bt_checker.sv
module bt_checker #(
  parameter int REG_W  = 32,
  parameter int MEM_W  = 8,
  parameter int FLAG_W = 5,
  parameter int Z_POS  = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [1:0]        op,
  input logic [REG_W-1:0]  dest_in,
  input logic              dest_is_mem,
  input logic [FLAG_W-1:0] flags_in,
  input logic              out_valid,
  input logic              wr_en,
  input logic [REG_W-1:0]  result,
  input logic [FLAG_W-1:0] flags_out
);
  localparam logic [FLAG_W-1:0] ZMASK = FLAG_W'(1) << Z_POS;

  a_r10_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  a_r11_idle_no_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid && !wr_en);
  a_r11_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(result) && $stable(flags_out));
  a_r8_wr_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> out_valid);
  a_r8_wr_modifying: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && op != 2'd0 |=> wr_en);
  a_r8_no_wr_test: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && op == 2'd0 |=> !wr_en);
  a_r2_test_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && op == 2'd0 && !dest_is_mem |=> result == $past(dest_in));
  a_r7_mem_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && dest_is_mem |=> result[REG_W-1:MEM_W] == '0);
  a_r9_flags_pass: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> ((flags_out ^ $past(flags_in)) & ~ZMASK) == '0);
  a_r3_one_bit_changes: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !dest_is_mem |=> $countones(result ^ $past(dest_in)) <= 1);
  a_r3_flip_changes: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && op == 2'd1 && !dest_is_mem |=> $countones(result ^ $past(dest_in)) == 1);
  a_r5_set_vs_z: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && op == 2'd3 && !dest_is_mem |=> (result != $past(dest_in)) == flags_out[Z_POS]);
  a_r4_clr_vs_z: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && op == 2'd2 && !dest_is_mem |=> (result != $past(dest_in)) == !flags_out[Z_POS]);
endmodule

bind bit_test_unit bt_checker #(
  .REG_W(REG_W), .MEM_W(MEM_W), .FLAG_W(FLAG_W), .Z_POS(Z_POS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .dest_in(dest_in),
  .dest_is_mem(dest_is_mem), .flags_in(flags_in), .out_valid(out_valid),
  .wr_en(wr_en), .result(result), .flags_out(flags_out)
);

// File: tb/bit_test_unit_tb.sv
module bit_test_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [1:0]  op = '0;
  logic [7:0]  bit_num = '0;
  logic [31:0] dest_in = '0;
  logic        dest_is_mem = 1'b0;
  logic [4:0]  flags_in = '0;
  logic        out_valid, wr_en;
  logic [31:0] result;
  logic [4:0]  flags_out;

  always #5 clk = ~clk;

  bit_test_unit u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .bit_num(bit_num),
    .dest_in(dest_in), .dest_is_mem(dest_is_mem), .flags_in(flags_in),
    .out_valid(out_valid), .wr_en(wr_en), .result(result), .flags_out(flags_out)
  );

  int n_chk = 0;
  int n_bad = 0;

  // reference model state: expectation for the next output cycle
  bit          pend = 0;
  logic [31:0] e_res = '0;
  logic [4:0]  e_flg = '0;
  bit          e_wr = 0;
  string       e_tag = "";

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic compare();
    if (pend) begin
      chk("R10 out_valid", 32'(out_valid), 32'd1);
      chk("R8 wr_en", 32'(wr_en), 32'(e_wr));
      chk(e_tag, result, e_res);
      chk("R1 zflag", 32'(flags_out[2]), 32'(e_flg[2]));
      chk("R9 other flags", 32'(flags_out & 5'b11011), 32'(e_flg & 5'b11011));
    end else begin
      chk("R11 out_valid idle", 32'(out_valid), 32'd0);
      chk("R11 wr_en idle", 32'(wr_en), 32'd0);
      chk("R11 result held", result, e_res);
      chk("R11 flags held", 32'(flags_out), 32'(e_flg));
    end
  endtask

  task automatic step(bit v, int o, int bn, logic [31:0] d, bit m, logic [4:0] f);
    @(negedge clk);
    compare();
    in_valid = v; op = 2'(o); bit_num = 8'(bn); dest_in = d; dest_is_mem = m; flags_in = f;
    pend = v;
    if (v) begin
      int          idx;
      logic [31:0] base;
      bit          old;
      idx  = m ? (bn % 8) : (bn % 32);
      base = m ? (d & 32'h0000_00FF) : d;
      old  = base[idx];
      case (o)
        1: base[idx] = ~old;
        2: base[idx] = 1'b0;
        3: base[idx] = 1'b1;
        default: ;
      endcase
      e_res = base;
      e_flg = f;
      e_flg[2] = ~old;
      e_wr  = (o != 0);
      if (m) e_tag = "R7 mem result";
      else if (bn >= 32) e_tag = "R6 wrapped result";
      else case (o)
        0: e_tag = "R2 test result";
        1: e_tag = "R3 change result";
        2: e_tag = "R4 clear result";
        default: e_tag = "R5 set result";
      endcase
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R10 reset out_valid", 32'(out_valid), 32'd0);
    chk("R10 reset wr_en", 32'(wr_en), 32'd0);
    chk("R10 reset result", result, 32'd0);
    chk("R10 reset flags", 32'(flags_out), 32'd0);
    rst_n = 1'b1;
    step(1, 0, 0,   32'h0000_0001, 0, 5'b10001);
    step(1, 1, 31,  32'h0000_0000, 0, 5'b01010);
    step(1, 2, 5,   32'hFFFF_FFDF, 0, 5'b11111);
    step(1, 3, 7,   32'h0000_0080, 0, 5'b00000);
    step(0, 0, 0,   32'hDEAD_BEEF, 0, 5'b11111);
    step(0, 3, 2,   32'h1234_5678, 1, 5'b00100);
    step(1, 3, 40,  32'h0000_0000, 0, 5'b00100);
    step(1, 1, 33,  32'hFFFF_FFFF, 0, 5'b10000);
    step(1, 0, 255, 32'h8000_0000, 0, 5'b01000);
    step(1, 2, 9,   32'hABCD_EF02, 1, 5'b00011);
    step(1, 3, 7,   32'hFFFF_FF00, 1, 5'b10101);
    step(1, 0, 12,  32'h5555_5510, 1, 5'b00000);
    step(1, 1, 200, 32'h0000_00FF, 1, 5'b11011);
    for (int i = 0; i < 400; i++) begin
      step(($urandom % 5) != 0, int'($urandom % 4), int'($urandom % 256),
           32'($urandom), bit'($urandom % 2), 5'($urandom));
    end
    step(0, 0, 0, 32'h0, 0, 5'b0);
    step(0, 0, 0, 32'h0, 0, 5'b0);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule